// File: doc/BRIEF.md
# Authenticated Page Read Responder

This block is the device-side sequencer for an authenticated page read on a byte-serial memory part. A master sends a command byte and a two-byte target address. The responder then streams the rest of the addressed 32-byte page, or filler bytes if the address lies outside the 128-byte array. A single filler byte and an inverted CRC16 follow, covering everything exchanged so far.

The responder then pulses a start request to an external hash engine and goes silent until the engine reports completion. Next it streams the 20-byte message authentication code, followed by an inverted CRC16 of those 20 bytes. From then on every read returns a fixed tail pattern until the sequencer is reset. The bit-level line timing, the hash core and the storage array sit outside this block.

The block uses two byte handshakes. Received bytes arrive with `rx_valid`. Each transmit byte is pulled by a one-cycle `tx_req` and answered on the next cycle with `tx_valid`. States, in order: `ST_IDLE` (wait for command), `ST_ADDR_LO`, `ST_ADDR_HI`, `ST_DATA`, `ST_FILL`, `ST_CRC1_LO`, `ST_CRC1_HI`, `ST_HASH_START`, `ST_HASH_WAIT`, `ST_MAC`, `ST_CRC2_LO`, `ST_CRC2_HI`, `ST_TAIL`. Each transmit state advances to the next one on an accepted `tx_req`, except in two cases: `ST_DATA` waits for its last offset and `ST_MAC` waits for its twentieth byte. `ST_HASH_START` lasts one cycle. `ST_HASH_WAIT` leaves on `hash_done`. `ST_TAIL` never leaves. `bus_reset` forces `ST_IDLE` from any state.

Top module: `auth_page_reader`

## Requirements
- R1: In `ST_IDLE` a received byte equal to the command code (default A5h) starts a transaction; any other byte is ignored and the block stays silent. The next two received bytes are the address low byte, then the address high byte.
- R2: Accepting the address high byte clears the `seq_arm` flag before any data byte is sent. `arm_set` sets the flag, and reset clears it.
- R3: For a 16-bit target address below 0080h, the data phase returns memory bytes from that address to the end of its 32-byte page. That is 32 minus the low five address bits, and `mem_addr` is formed as {address[6:5], running offset}.
- R4: For a target address of 0080h or above, the data phase returns FFh bytes, with the same count as R3 computes.
- R5: After the data phase the block sends one FFh byte. It then sends the bitwise inverse of the CRC16 over command, address low, address high, every data byte and that FFh byte, low byte first. The CRC uses polynomial x^16+x^15+x^2+1, a zero seed and LSB-first bit order (reflected constant A001h).
- R6: After the high CRC byte is taken, `hash_start` is high for exactly one cycle. `hash_page` gives address bits [6:5]. No byte is delivered until `hash_done` is seen high.
- R7: The 20 MAC bytes are sent least significant byte of `hash_mac` first. The value used is the one present in the cycle `hash_done` was seen.
- R8: After the MAC the block sends the inverted CRC16 of the 20 MAC bytes, from a fresh zero seed, low byte first.
- R9: Every read after the second CRC returns AAh, repeating until reset.
- R10: `bus_reset` returns the sequencer to `ST_IDLE` from any state, clears `tx_valid` and discards the partial CRC. A later transaction sees a zero seed.
- R11: `tx_valid` rises only in the cycle after an accepted `tx_req`. A `tx_req` outside a transmit state produces no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Synchronous return to idle |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Request for the next transmit byte |
| tx_valid | output | 1 | Transmit byte valid (cycle after request) |
| tx_byte | output | 8 | Transmit byte |
| mem_addr | output | 7 | Memory read address |
| mem_rdata | input | 8 | Memory read data (combinational) |
| arm_set | input | 1 | Sets the arm flag |
| seq_arm | output | 1 | Arm flag, cleared when an address is accepted |
| hash_start | output | 1 | One-cycle hash start request |
| hash_done | input | 1 | Hash complete level |
| hash_mac | input | 160 | Hash result |
| hash_page | output | 2 | Selected page index for the hash engine |

## Verification
Some properties are checked by assertions on every cycle:
- the one-cycle start pulse;
- silence while the hash engine is busy;
- `tx_valid` appearing only after a request;
- the arm flag being clear when the data phase begins;
- the tail state holding;
- `bus_reset` forcing idle.

Byte values and counts can only be shown by the bench scenarios. These cover the page-relative byte count and the FFh substitution for out-of-range addresses. They also cover both CRC values, MAC byte order and latching, the AAh tail, and the fresh CRC seed after an aborted transaction.

// File: rtl/apr_pkg.sv
package apr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR_LO,
        ST_ADDR_HI,
        ST_DATA,
        ST_FILL,
        ST_CRC1_LO,
        ST_CRC1_HI,
        ST_HASH_START,
        ST_HASH_WAIT,
        ST_MAC,
        ST_CRC2_LO,
        ST_CRC2_HI,
        ST_TAIL
    } apr_state_e;

    localparam logic [15:0] CRC_POLY_REFL = 16'hA001;

    // One byte of reflected CRC16, LSB of the data first.
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/apr_crc16.sv
module apr_crc16
    import apr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   crc <= '0;
        else if (clr) crc <= '0;
        else if (en)  crc <= crc16_step(crc, din);
    end
endmodule

// File: rtl/apr_mac_buf.sv
module apr_mac_buf #(
    parameter int MAC_BYTES = 20,
    localparam int MAC_W    = MAC_BYTES * 8,
    localparam int IDX_W    = $clog2(MAC_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [MAC_W-1:0] mac_in,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       byte_o
);
    logic [MAC_W-1:0] mac_q;
    logic [7:0]       lane [MAC_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    mac_q <= '0;
        else if (load) mac_q <= mac_in;
    end

    for (genvar g = 0; g < MAC_BYTES; g++) begin : g_lane
        assign lane[g] = mac_q[g*8 +: 8];
    end

    always_comb begin
        byte_o = '0;
        for (int k = 0; k < MAC_BYTES; k++)
            if (idx == IDX_W'(k)) byte_o = lane[k];
    end
endmodule

// File: rtl/auth_page_reader.sv
module auth_page_reader
    import apr_pkg::*;
#(
    parameter logic [7:0] CMD_CODE   = 8'hA5,
    parameter int         PAGE_BYTES = 32,
    parameter int         MEM_BYTES  = 128,
    parameter int         MAC_BYTES  = 20,
    parameter logic [7:0] FILL_BYTE  = 8'hFF,
    parameter logic [7:0] TAIL_BYTE  = 8'hAA,
    localparam int        OFS_W      = $clog2(PAGE_BYTES),
    localparam int        ADDR_W     = $clog2(MEM_BYTES),
    localparam int        PG_W       = ADDR_W - OFS_W,
    localparam int        MAC_W      = MAC_BYTES * 8,
    localparam int        IDX_W      = $clog2(MAC_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              tx_req,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    input  logic              arm_set,
    output logic              seq_arm,
    output logic              hash_start,
    input  logic              hash_done,
    input  logic [MAC_W-1:0]  hash_mac,
    output logic [PG_W-1:0]   hash_page
);
    apr_state_e       state, state_nx;
    logic [7:0]       ta_lo, ta_hi;
    logic [OFS_W-1:0] offs;
    logic [IDX_W-1:0] mac_idx;
    logic [15:0]      crc;
    logic [7:0]       mac_byte, cur_byte, crc_din;
    logic             addr_ok, rx_state, sending, rx_take, tx_take;
    logic             crc_en, crc_clr, mac_load;

    // ---------------- decode ----------------
    assign addr_ok    = ({ta_hi, ta_lo} < 16'(MEM_BYTES));
    assign mem_addr   = {ta_lo[ADDR_W-1:OFS_W], offs};
    assign hash_page  = ta_lo[ADDR_W-1:OFS_W];
    assign hash_start = (state == ST_HASH_START);
    assign mac_load   = (state == ST_HASH_WAIT) && hash_done;

    assign rx_state = (state == ST_IDLE) || (state == ST_ADDR_LO) || (state == ST_ADDR_HI);
    assign sending  = (state == ST_DATA)    || (state == ST_FILL)    ||
                      (state == ST_CRC1_LO) || (state == ST_CRC1_HI) ||
                      (state == ST_MAC)     || (state == ST_CRC2_LO) ||
                      (state == ST_CRC2_HI) || (state == ST_TAIL);
    assign rx_take  = rx_valid && rx_state &&
                      ((state != ST_IDLE) || (rx_byte == CMD_CODE));
    assign tx_take  = tx_req && sending;

    always_comb begin
        unique case (state)
            ST_DATA:               cur_byte = addr_ok ? mem_rdata : FILL_BYTE;
            ST_CRC1_LO, ST_CRC2_LO: cur_byte = ~crc[7:0];
            ST_CRC1_HI, ST_CRC2_HI: cur_byte = ~crc[15:8];
            ST_MAC:                cur_byte = mac_byte;
            ST_TAIL:               cur_byte = TAIL_BYTE;
            default:               cur_byte = FILL_BYTE;
        endcase
    end

    assign crc_din = rx_state ? rx_byte : cur_byte;
    assign crc_en  = rx_take ||
                     (tx_take && ((state == ST_DATA) || (state == ST_FILL) || (state == ST_MAC)));
    assign crc_clr = bus_reset || (state == ST_HASH_START);

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (rx_take) state_nx = ST_ADDR_LO;
            ST_ADDR_LO:    if (rx_take) state_nx = ST_ADDR_HI;
            ST_ADDR_HI:    if (rx_take) state_nx = ST_DATA;
            ST_DATA:       if (tx_take && offs == OFS_W'(PAGE_BYTES - 1)) state_nx = ST_FILL;
            ST_FILL:       if (tx_take) state_nx = ST_CRC1_LO;
            ST_CRC1_LO:    if (tx_take) state_nx = ST_CRC1_HI;
            ST_CRC1_HI:    if (tx_take) state_nx = ST_HASH_START;
            ST_HASH_START: state_nx = ST_HASH_WAIT;
            ST_HASH_WAIT:  if (hash_done) state_nx = ST_MAC;
            ST_MAC:        if (tx_take && mac_idx == IDX_W'(MAC_BYTES - 1)) state_nx = ST_CRC2_LO;
            ST_CRC2_LO:    if (tx_take) state_nx = ST_CRC2_HI;
            ST_CRC2_HI:    if (tx_take) state_nx = ST_TAIL;
            ST_TAIL:       state_nx = ST_TAIL;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         state <= ST_IDLE;
        else if (bus_reset) state <= ST_IDLE;
        else                state <= state_nx;
    end

    // ---------------- outputs and context ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
            seq_arm  <= 1'b0;
            ta_lo    <= '0;
            ta_hi    <= '0;
            offs     <= '0;
            mac_idx  <= '0;
        end else if (bus_reset) begin
            tx_valid <= 1'b0;
            offs     <= '0;
            mac_idx  <= '0;
        end else begin
            tx_valid <= tx_take;
            if (tx_take) tx_byte <= cur_byte;
            if (state == ST_ADDR_LO && rx_take) ta_lo <= rx_byte;
            if (state == ST_ADDR_HI && rx_take) begin
                ta_hi   <= rx_byte;
                offs    <= ta_lo[OFS_W-1:0];
                seq_arm <= 1'b0;
            end else if (arm_set) begin
                seq_arm <= 1'b1;
            end
            if (state == ST_DATA && tx_take) offs <= offs + 1'b1;
            if (mac_load) mac_idx <= '0;
            else if (state == ST_MAC && tx_take) mac_idx <= mac_idx + 1'b1;
        end
    end

    apr_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .din   (crc_din),
        .crc   (crc)
    );

    apr_mac_buf #(.MAC_BYTES(MAC_BYTES)) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (mac_load),
        .mac_in (hash_mac),
        .idx    (mac_idx),
        .byte_o (mac_byte)
    );

    // ---------------- assertions ----------------
    AST_ARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && $past(state) == ST_ADDR_HI) |-> !seq_arm); // R2
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        hash_start |=> !hash_start); // R6
    AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_HASH_WAIT) |-> !tx_valid); // R6
    AST_TAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL && !bus_reset) |=> (state == ST_TAIL)); // R9
    AST_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (state == ST_IDLE && !tx_valid)); // R10
    AST_TX_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(tx_req)); // R11
endmodule

// File: tb/auth_page_reader_tb.sv
`timescale 1ns/1ps
module auth_page_reader_tb;
    localparam real CLK_NS = 8.0;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_reset = 1'b0;
    logic         rx_valid = 1'b0;
    logic [7:0]   rx_byte = '0;
    logic         tx_req = 1'b0;
    logic         tx_valid;
    logic [7:0]   tx_byte;
    logic [6:0]   mem_addr;
    logic [7:0]   mem_rdata;
    logic         arm_set = 1'b0;
    logic         seq_arm;
    logic         hash_start;
    logic         hash_done = 1'b0;
    logic [159:0] hash_mac = '0;
    logic [1:0]   hash_page;

    int checks = 0;
    int errors = 0;

    always #(CLK_NS/2) clk = ~clk;

    function automatic logic [7:0] mem_val(input logic [6:0] a);
        return 8'({1'b0, a} * 8'd13 + 8'h5A);
    endfunction
    assign mem_rdata = mem_val(mem_addr);

    auth_page_reader u_dut (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_req(tx_req), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .arm_set(arm_set), .seq_arm(seq_arm),
        .hash_start(hash_start), .hash_done(hash_done),
        .hash_mac(hash_mac), .hash_page(hash_page)
    );

    // Bench CRC: shift register form, LSB first, reflected constant
    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] s;
        logic fb;
        s = c;
        for (int b = 0; b < 8; b++) begin
            fb = s[0] ^ d[b];
            s = {1'b0, s[15:1]};
            if (fb) s = s ^ 16'hA001;
        end
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_rx(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic read_byte(output logic [7:0] b, output logic v);
        @(negedge clk);
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
        b = tx_byte;
        v = tx_valid;
    endtask

    function automatic logic [159:0] make_mac(input logic [7:0] seed);
        logic [159:0] m;
        for (int i = 0; i < 20; i++) m[i*8 +: 8] = 8'(seed + 8'(i * 7));
        return m;
    endfunction

    // Full authenticated read at address {hi,lo}
    task automatic run_auth(input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] seed);
        logic [15:0] c;
        logic [7:0]  b, e;
        logic        v;
        logic [159:0] mac;
        int          n;
        bit          ok_addr;
        c = 16'h0;
        c = ref_crc(c, 8'hA5);
        c = ref_crc(c, lo);
        c = ref_crc(c, hi);
        @(negedge clk); arm_set = 1'b1; @(negedge clk); arm_set = 1'b0;
        chk(seq_arm == 1'b1, "R2 arm set", 32'(seq_arm), 1);
        send_rx(8'hA5);
        send_rx(lo);
        send_rx(hi);
        chk(seq_arm == 1'b0, "R2 arm cleared on address", 32'(seq_arm), 0);
        ok_addr = ({hi, lo} < 16'h0080);
        n = 32 - int'(lo[4:0]);
        for (int i = 0; i < n; i++) begin
            read_byte(b, v);
            e = ok_addr ? mem_val(7'(lo[6:0] + 7'(i))) : 8'hFF;
            chk(v && b == e, ok_addr ? "R3 page data" : "R4 filler data", {23'd0, v, b}, {24'd1, e});
            c = ref_crc(c, e);
        end
        read_byte(b, v);
        chk(v && b == 8'hFF, "R5 trailing FF", {23'd0, v, b}, 32'h1FF);
        c = ref_crc(c, 8'hFF);
        read_byte(b, v);
        chk(b == ~c[7:0], "R5 crc low", 32'(b), 32'(~c[7:0]));
        read_byte(b, v);
        chk(b == ~c[15:8], "R5 crc high", 32'(b), 32'(~c[15:8]));
        chk(hash_start == 1'b1, "R6 start pulse", 32'(hash_start), 1);
        chk(hash_page == lo[6:5], "R6 page index", 32'(hash_page), 32'(lo[6:5]));
        @(negedge clk);
        chk(hash_start == 1'b0, "R6 start one cycle", 32'(hash_start), 0);
        read_byte(b, v);
        chk(v == 1'b0, "R6 silent while hashing", 32'(v), 0);
        mac = make_mac(seed);
        hash_mac  = mac;
        hash_done = 1'b1;
        @(negedge clk);
        hash_done = 1'b0;
        hash_mac  = ~mac;
        c = 16'h0;
        for (int i = 0; i < 20; i++) begin
            read_byte(b, v);
            chk(v && b == mac[i*8 +: 8], "R7 mac byte", {23'd0, v, b}, {24'd1, mac[i*8 +: 8]});
            c = ref_crc(c, mac[i*8 +: 8]);
        end
        read_byte(b, v);
        chk(b == ~c[7:0], "R8 mac crc low", 32'(b), 32'(~c[7:0]));
        read_byte(b, v);
        chk(b == ~c[15:8], "R8 mac crc high", 32'(b), 32'(~c[15:8]));
        for (int i = 0; i < 3; i++) begin
            read_byte(b, v);
            chk(v && b == 8'hAA, "R9 tail", {23'd0, v, b}, 32'h1AA);
        end
    endtask

    task automatic pulse_bus_reset();
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
        chk(tx_valid == 1'b0, "R10 tx cleared by bus reset", 32'(tx_valid), 0);
    endtask

    task automatic t_reset();
        chk(tx_valid == 1'b0, "R11 reset tx_valid", 32'(tx_valid), 0);
        chk(seq_arm == 1'b0, "R2 reset arm", 32'(seq_arm), 0);
        chk(hash_start == 1'b0, "R6 reset start", 32'(hash_start), 0);
    endtask

    task automatic t_bad_cmd();
        logic [7:0] b;
        logic v;
        send_rx(8'h3C);
        read_byte(b, v);
        chk(v == 1'b0, "R1 wrong command ignored", 32'(v), 0);
        read_byte(b, v);
        chk(v == 1'b0, "R11 no byte in idle", 32'(v), 0);
    endtask

    task automatic t_abort();
        logic [7:0] b;
        logic v;
        send_rx(8'hA5);
        send_rx(8'h22);
        send_rx(8'h00);
        read_byte(b, v);
        chk(v && b == mem_val(7'h22), "R3 first byte before abort", {23'd0, v, b}, {24'd1, mem_val(7'h22)});
        read_byte(b, v);
        pulse_bus_reset();
        read_byte(b, v);
        chk(v == 1'b0, "R10 idle after bus reset", 32'(v), 0);
    endtask

    initial begin
        #(CLK_NS * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bad_cmd();
        run_auth(8'h00, 8'h00, 8'h11);   // R3 full page
        pulse_bus_reset();
        run_auth(8'h45, 8'h00, 8'h42);   // R3 mid page
        pulse_bus_reset();
        run_auth(8'h7F, 8'h00, 8'h90);   // R3 single byte
        pulse_bus_reset();
        run_auth(8'h90, 8'h00, 8'h05);   // R4 low byte out of range
        pulse_bus_reset();
        run_auth(8'h00, 8'h01, 8'hC3);   // R4 high byte out of range
        pulse_bus_reset();
        t_abort();
        run_auth(8'h33, 8'h00, 8'h77);   // R10 fresh CRC after abort
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule